// File: doc/BRIEF.md
# Memory Deep Power-Down Entry Sequencer

This block is the controller-side sequencer that carries a low-power SDRAM from normal operation into deep power-down. It watches the power-management controls, the request stream and optional hardware low-power gating. Once every entry condition holds, it walks through a fixed order of steps. First come any refreshes owed after an earlier self-refresh exit. Then every open bank is precharged, one bank per clock. After a row-precharge wait, the deep power-down command goes to all ranks in the same cycle. When enabled, a delayed low-power request on the DFI side follows, held until acknowledge or timeout.

A read or write request, or a cleared enable, during the refresh step or the precharge-wait step abandons the attempt. The block then reports an abort for one cycle and returns to idle, where the idle period must elapse again. After the entry command has gone out, nothing can pull the block back. Only reset leaves deep power-down, because exit sequencing belongs to another block. Each command appears on the command outputs for one clock with a single-cycle valid strobe.

Top module: `dpd_entry_seq`

## Requirements
- R1: Entry starts only while `dpd_en`=1, `sr_en`=0, `sr_sw`=0 and `req_valid`=0, and the idle period has elapsed. `status` encodes 0 idle, 1 entering, 2 aborted, 3 in deep power-down. After reset, `status`=0, `cmd_cke`=1, `cmd_valid`=0, `cmd_cs_n` is all ones and `dfi_lp_req`=0.
- R2: The idle period is 32*`idle_x32` clocks and restarts on every request and whenever the block leaves idle. If `req_valid` is last sampled high at edge e0, then `status` is still 0 after edge e0+P and becomes 1 after edge e0+P+1, where P=32*`idle_x32`.
- R3: With `hwlp_en`=1, entry waits for `hwlp_sr_done`=1. With `act_gate_en`=1, entry waits until every bit of `activity` is 0. With `act_gate_en`=0, `activity` is ignored.
- R4: After a pulse on `sr_exit_pulse`, the next entry first issues one all-bank refresh (kind 0, bank 0). If `per_bank_ref`=1, it instead issues eight per-bank refreshes (kind 1) to banks 0 to 7 in order. With no self-refresh exit pending, no refresh is issued. An aborted attempt leaves the obligation pending.
- R5: Each bank set in `open_banks` gets exactly one precharge (kind 2). The precharges go out on consecutive clocks in ascending bank order.
- R6: The entry command follows the last precharge by exactly `trp_cyc`+2 clocks.
- R7: The entry command is kind 3, with `cmd_cke`=0, `cmd_cs_n` all zero and `cmd_ca`=3'b011 (CA0=1, CA1=1, CA2=0). Refresh and precharge commands have `cmd_cke`=1, `cmd_cs_n` all zero and `cmd_ca`=0.
- R8: `req_valid`=1 or `dpd_en`=0 during the refresh step or the precharge-wait step aborts the attempt. `status` shows 2 for one clock, then 0, and no further command is issued while the condition holds.
- R9: After the entry command, `status` stays 3 and `cmd_cke` stays 0, and no command is issued, whatever the requests or enables do, until reset.
- R10: With `dfi_lp_dpd_en`=1, `dfi_lp_req` rises max(D,1) clocks after the entry command, where D=`t_ctrl_delay`+`t_ckdpde`. It carries `dfi_wakeup_cfg` on `dfi_lp_wakeup`. With `dfi_lp_dpd_en`=0, it never rises.
- R11: `dfi_lp_req` falls on the clock edge that samples `dfi_lp_ack`=1. Without an acknowledge, it stays high for max(`dfi_timeout`,1) clocks.
- R12: A request during the precharge step does not abort the attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dpd_en | input | 1 | Deep power-down enable |
| sr_en | input | 1 | Self-refresh enable (blocks entry) |
| sr_sw | input | 1 | Software self-refresh control (blocks entry) |
| per_bank_ref | input | 1 | Use per-bank refreshes after a self-refresh exit |
| sr_exit_pulse | input | 1 | Marks a completed self-refresh exit |
| hwlp_en | input | 1 | Hardware low-power interface enabled |
| hwlp_sr_done | input | 1 | Hardware interface finished its self-refresh exit |
| act_gate_en | input | 1 | Require the activity vector to be all zero |
| activity | input | ACT_W | Activity inputs from the system |
| req_valid | input | 1 | Read or write request seen |
| open_banks | input | NUM_BANKS | Bitmap of open banks |
| idle_x32 | input | IDLE_W | Idle period in 32-clock units |
| trp_cyc | input | TW | Row-precharge wait in clocks |
| t_ctrl_delay | input | TW | Control delay part of the DFI request delay |
| t_ckdpde | input | TW | Clock-disable part of the DFI request delay |
| dfi_timeout | input | TW | DFI request hold limit in clocks |
| dfi_lp_dpd_en | input | 1 | Enable the DFI low-power request |
| dfi_wakeup_cfg | input | WAKE_W | Wakeup value to present with the request |
| dfi_lp_ack | input | 1 | DFI low-power acknowledge |
| cmd_valid | output | 1 | One-clock strobe per command |
| cmd_kind | output | 2 | 0 all-bank refresh, 1 per-bank refresh, 2 precharge, 3 deep power-down |
| cmd_bank | output | BANK_W | Target bank |
| cmd_cke | output | 1 | Clock enable |
| cmd_cs_n | output | NUM_RANKS | Chip selects, active low |
| cmd_ca | output | 3 | Command/address bits 2..0 |
| dfi_lp_req | output | 1 | DFI low-power request |
| dfi_lp_wakeup | output | WAKE_W | Wakeup value sent with the request |
| status | output | 2 | Sequencer status |

## Verification
A wrong internal state shows up mostly in the command log. A stale done-bank mask repeats or skips a precharge within a clock of the fault. A step counter that is off by one moves the entry command or the DFI request edge by exactly one clock, which an exact cycle comparison catches. If the abort path looks at the wrong step, a late request either fails to stop the attempt or stops one that should have gone on. The `status` code shows this on the very next clock. A leak out of the power-down state raises `cmd_cke` again, where it is visible at once.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REF, S_PRE, S_TRP, S_ABORT, S_DFI_DLY, S_DFI_REQ, S_DPD
  } seq_state_e;

  typedef enum logic [1:0] {
    CK_REF_AB = 2'd0,
    CK_REF_PB = 2'd1,
    CK_PRE    = 2'd2,
    CK_DPD    = 2'd3
  } cmd_kind_e;

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_ENTER = 2'd1;
  localparam logic [1:0] ST_ABORT = 2'd2;
  localparam logic [1:0] ST_DPD   = 2'd3;
  localparam logic [2:0] CA_DPD   = 3'b011;
endpackage

// File: rtl/dpd_idle_gate.sv
module dpd_idle_gate #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [IDLE_W-1:0] idle_x32,
  output logic              idle_ok
);
  localparam int CNT_W = IDLE_W + 5;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;

  assign target  = {idle_x32, 5'b00000};
  assign idle_ok = (cnt >= target);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (cnt < target) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dpd_bank_pick.sv
module dpd_bank_pick #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_BANKS-1:0] vec,
  output logic                 any,
  output logic [BANK_W-1:0]    idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (vec[i]) idx = BANK_W'(i);
    end
  end
endmodule

// File: rtl/dpd_ref_tracker.sv
module dpd_ref_tracker #(
  parameter int T_RFC   = 4,
  parameter int PB_REFS = 8,
  parameter int BANK_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sr_exit_pulse,
  input  logic              load,
  input  logic              per_bank,
  input  logic              run,
  output logic              pending,
  output logic              issue,
  output logic              done,
  output logic [BANK_W-1:0] pb_idx
);
  localparam int LW = $clog2(PB_REFS + 1);
  localparam int GW = $clog2(T_RFC + 1);

  logic [LW-1:0]     left;
  logic [GW-1:0]     gap;
  logic [BANK_W-1:0] cnt;

  assign issue  = run && (gap == '0) && (left != '0);
  assign done   = run && (gap == '0) && (left == '0);
  assign pb_idx = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      left    <= '0;
      gap     <= '0;
      cnt     <= '0;
    end else begin
      if (sr_exit_pulse) pending <= 1'b1;
      else if (done)     pending <= 1'b0;

      if (load) begin
        left <= per_bank ? LW'(PB_REFS) : LW'(1);
        gap  <= '0;
        cnt  <= '0;
      end else if (run) begin
        if (gap != '0) begin
          gap <= gap - 1'b1;
        end else if (left != '0) begin
          left <= left - 1'b1;
          gap  <= GW'(T_RFC);
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dpd_entry_seq.sv
module dpd_entry_seq
  import dpd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int NUM_RANKS = 2,
  parameter int ACT_W     = 4,
  parameter int IDLE_W    = 8,
  parameter int TW        = 8,
  parameter int WAKE_W    = 4,
  parameter int T_RFC     = 4,
  parameter int PB_REFS   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       dpd_en,
  input  logic                       sr_en,
  input  logic                       sr_sw,
  input  logic                       per_bank_ref,
  input  logic                       sr_exit_pulse,
  input  logic                       hwlp_en,
  input  logic                       hwlp_sr_done,
  input  logic                       act_gate_en,
  input  logic [ACT_W-1:0]           activity,
  input  logic                       req_valid,
  input  logic [NUM_BANKS-1:0]       open_banks,
  input  logic [IDLE_W-1:0]          idle_x32,
  input  logic [TW-1:0]              trp_cyc,
  input  logic [TW-1:0]              t_ctrl_delay,
  input  logic [TW-1:0]              t_ckdpde,
  input  logic [TW-1:0]              dfi_timeout,
  input  logic                       dfi_lp_dpd_en,
  input  logic [WAKE_W-1:0]          dfi_wakeup_cfg,
  input  logic                       dfi_lp_ack,
  output logic                       cmd_valid,
  output logic [1:0]                 cmd_kind,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic                       cmd_cke,
  output logic [NUM_RANKS-1:0]       cmd_cs_n,
  output logic [2:0]                 cmd_ca,
  output logic                       dfi_lp_req,
  output logic [WAKE_W-1:0]          dfi_lp_wakeup,
  output logic [1:0]                 status
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int DW     = TW + 1;

  seq_state_e state, state_nx;
  logic              idle_ok, cond_ok, abort_hit, go;
  logic [NUM_BANKS-1:0] done_mask, pend_banks;
  logic              pick_any;
  logic [BANK_W-1:0] pick_idx;
  logic              ref_pending, ref_issue, ref_done;
  logic [BANK_W-1:0] ref_idx;
  logic [TW-1:0]     trp_cnt, tmo_cnt;
  logic [DW-1:0]     dly_cnt, delay_sum;
  logic              iss_v;
  cmd_kind_e         iss_k;
  logic [BANK_W-1:0] iss_b;

  dpd_idle_gate #(.IDLE_W(IDLE_W)) u_idle (
    .clk(clk), .rst(rst),
    .clear(req_valid || (state != S_IDLE)),
    .idle_x32(idle_x32), .idle_ok(idle_ok)
  );

  assign pend_banks = open_banks & ~done_mask;

  dpd_bank_pick #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_pick (
    .vec(pend_banks), .any(pick_any), .idx(pick_idx)
  );

  dpd_ref_tracker #(.T_RFC(T_RFC), .PB_REFS(PB_REFS), .BANK_W(BANK_W)) u_ref (
    .clk(clk), .rst(rst), .sr_exit_pulse(sr_exit_pulse), .load(go),
    .per_bank(per_bank_ref), .run((state == S_REF) && !abort_hit),
    .pending(ref_pending), .issue(ref_issue), .done(ref_done), .pb_idx(ref_idx)
  );

  assign cond_ok = dpd_en && !sr_en && !sr_sw && !req_valid && idle_ok &&
                   (!hwlp_en || hwlp_sr_done) &&
                   (!act_gate_en || (activity == '0));
  assign abort_hit = req_valid || !dpd_en;
  assign delay_sum = {1'b0, t_ctrl_delay} + {1'b0, t_ckdpde};

  always_comb begin
    state_nx = state;
    go       = 1'b0;
    iss_v    = 1'b0;
    iss_k    = CK_REF_AB;
    iss_b    = '0;
    case (state)
      S_IDLE: if (cond_ok) begin
        go       = 1'b1;
        state_nx = ref_pending ? S_REF : S_PRE;
      end
      S_REF: begin
        if (abort_hit) state_nx = S_ABORT;
        else if (ref_issue) begin
          iss_v = 1'b1;
          iss_k = per_bank_ref ? CK_REF_PB : CK_REF_AB;
          iss_b = per_bank_ref ? ref_idx : '0;
        end else if (ref_done) state_nx = S_PRE;
      end
      S_PRE: begin
        if (pick_any) begin
          iss_v = 1'b1;
          iss_k = CK_PRE;
          iss_b = pick_idx;
        end else state_nx = S_TRP;
      end
      S_TRP: begin
        if (abort_hit) state_nx = S_ABORT;
        else if (trp_cnt == '0) begin
          iss_v    = 1'b1;
          iss_k    = CK_DPD;
          state_nx = dfi_lp_dpd_en ? S_DFI_DLY : S_DPD;
        end
      end
      S_ABORT:   state_nx = S_IDLE;
      S_DFI_DLY: if (dly_cnt <= DW'(1)) state_nx = S_DFI_REQ;
      S_DFI_REQ: if (dfi_lp_ack || (tmo_cnt <= TW'(1))) state_nx = S_DPD;
      default:   state_nx = S_DPD;
    endcase
  end

  always_comb begin
    case (state)
      S_IDLE:                status = ST_IDLE;
      S_REF, S_PRE, S_TRP:   status = ST_ENTER;
      S_ABORT:               status = ST_ABORT;
      default:               status = ST_DPD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      done_mask     <= '0;
      trp_cnt       <= '0;
      dly_cnt       <= '0;
      tmo_cnt       <= '0;
      cmd_valid     <= 1'b0;
      cmd_kind      <= CK_REF_AB;
      cmd_bank      <= '0;
      cmd_cke       <= 1'b1;
      cmd_cs_n      <= '1;
      cmd_ca        <= '0;
      dfi_lp_req    <= 1'b0;
      dfi_lp_wakeup <= '0;
    end else begin
      state     <= state_nx;
      cmd_valid <= iss_v;
      cmd_kind  <= iss_k;
      cmd_bank  <= iss_b;
      cmd_cs_n  <= iss_v ? '0 : '1;
      cmd_ca    <= (iss_v && iss_k == CK_DPD) ? CA_DPD : 3'b000;
      if (iss_v && iss_k == CK_DPD) begin
        cmd_cke <= 1'b0;
        dly_cnt <= delay_sum;
      end
      if (go) done_mask <= '0;
      else if (iss_v && iss_k == CK_PRE) done_mask[iss_b] <= 1'b1;
      case (state)
        S_PRE: if (!pick_any) trp_cnt <= trp_cyc;
        S_TRP: if (!abort_hit && trp_cnt != '0) trp_cnt <= trp_cnt - 1'b1;
        S_DFI_DLY: begin
          if (dly_cnt <= DW'(1)) begin
            dfi_lp_req    <= 1'b1;
            dfi_lp_wakeup <= dfi_wakeup_cfg;
            tmo_cnt       <= dfi_timeout;
          end else dly_cnt <= dly_cnt - 1'b1;
        end
        S_DFI_REQ: begin
          if (state_nx == S_DPD) begin
            dfi_lp_req    <= 1'b0;
            dfi_lp_wakeup <= '0;
          end else tmo_cnt <= tmo_cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R1: a step from idle to entering needs the enable, cleared self-refresh controls and no request
  a_r1_entry_gate: assert property (@(posedge clk) disable iff (rst)
    (status == ST_ENTER && $past(status) == ST_IDLE) |->
      $past(dpd_en && !sr_en && !sr_sw && !req_valid));

  // R5: back-to-back precharges climb in bank number
  a_r5_pre_ascending: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CK_PRE && $past(cmd_valid && cmd_kind == CK_PRE)) |->
      (cmd_bank > $past(cmd_bank)));

  // R8: an abort only follows an entry attempt
  a_r8_abort_source: assert property (@(posedge clk) disable iff (rst)
    (status == ST_ABORT) |-> ($past(status) == ST_ENTER));

  // R9: once clock enable drops, it never rises again and the state is power-down
  a_r9_cke_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_cke |=> !cmd_cke);
  a_r9_cke_status: assert property (@(posedge clk) disable iff (rst)
    !cmd_cke |-> (status == ST_DPD));

  // R10: the DFI request appears only inside deep power-down
  a_r10_req_in_dpd: assert property (@(posedge clk) disable iff (rst)
    dfi_lp_req |-> (status == ST_DPD && !cmd_cke));
endmodule

// File: tb/dpd_entry_seq_bench.sv
module dpd_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dpd_en, sr_en, sr_sw, per_bank_ref, sr_exit_pulse;
  logic hwlp_en, hwlp_sr_done, act_gate_en, req_valid;
  logic [3:0] activity;
  logic [7:0] open_banks, idle_x32, trp_cyc, t_ctrl_delay, t_ckdpde, dfi_timeout;
  logic dfi_lp_dpd_en, dfi_lp_ack;
  logic [3:0] dfi_wakeup_cfg;
  logic cmd_valid, cmd_cke, dfi_lp_req;
  logic [1:0] cmd_kind, status;
  logic [2:0] cmd_bank, cmd_ca;
  logic [1:0] cmd_cs_n;
  logic [3:0] dfi_lp_wakeup;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int lg_n = 0;
  int lg_kind [64];
  int lg_bank [64];
  int lg_cyc  [64];
  int rise_cyc = -1;
  int fall_cyc = -1;
  int rise_wake = 0;
  bit prev_req = 1'b0;
  bit finished = 1'b0;

  dpd_entry_seq u_dpd_entry_seq (
    .clk(clk), .rst(rst), .dpd_en(dpd_en), .sr_en(sr_en), .sr_sw(sr_sw),
    .per_bank_ref(per_bank_ref), .sr_exit_pulse(sr_exit_pulse),
    .hwlp_en(hwlp_en), .hwlp_sr_done(hwlp_sr_done), .act_gate_en(act_gate_en),
    .activity(activity), .req_valid(req_valid), .open_banks(open_banks),
    .idle_x32(idle_x32), .trp_cyc(trp_cyc), .t_ctrl_delay(t_ctrl_delay),
    .t_ckdpde(t_ckdpde), .dfi_timeout(dfi_timeout), .dfi_lp_dpd_en(dfi_lp_dpd_en),
    .dfi_wakeup_cfg(dfi_wakeup_cfg), .dfi_lp_ack(dfi_lp_ack),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_cke(cmd_cke), .cmd_cs_n(cmd_cs_n), .cmd_ca(cmd_ca),
    .dfi_lp_req(dfi_lp_req), .dfi_lp_wakeup(dfi_lp_wakeup), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int max1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  // command monitor: log every strobe and check its pin encoding (R7)
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      if (lg_n < 64) begin
        lg_kind[lg_n] = int'(cmd_kind);
        lg_bank[lg_n] = int'(cmd_bank);
        lg_cyc[lg_n]  = cyc;
        lg_n++;
      end
      if (cmd_kind == 2'd3)
        chk(!cmd_cke && cmd_cs_n == 2'b00 && cmd_ca == 3'b011, "R7", int'(cmd_ca), 3);
      else
        chk(cmd_cke && cmd_cs_n == 2'b00 && cmd_ca == 3'b000, "R7", int'(cmd_ca), 0);
    end
    if (dfi_lp_req && !prev_req) begin
      rise_cyc  = cyc;
      rise_wake = int'(dfi_lp_wakeup);
    end
    if (!dfi_lp_req && prev_req) fall_cyc = cyc;
    prev_req = dfi_lp_req;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    lg_n = 0;
    for (int i = 0; i < 64; i++) begin
      lg_kind[i] = -1; lg_bank[i] = -1; lg_cyc[i] = -1;
    end
    rise_cyc = -1;
    fall_cyc = -1;
  endtask

  task automatic do_reset();
    dpd_en = 0; sr_en = 0; sr_sw = 0; per_bank_ref = 0; sr_exit_pulse = 0;
    hwlp_en = 0; hwlp_sr_done = 0; act_gate_en = 0; activity = '0;
    req_valid = 0; open_banks = '0; idle_x32 = 8'd1; trp_cyc = 8'd2;
    t_ctrl_delay = 8'd1; t_ckdpde = 8'd1; dfi_timeout = 8'd4;
    dfi_lp_dpd_en = 0; dfi_wakeup_cfg = 4'h5; dfi_lp_ack = 0;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    clear_log();
  endtask

  task automatic sr_exit();
    sr_exit_pulse = 1'b1;
    tick(1);
    sr_exit_pulse = 1'b0;
  endtask

  // returns the cycle of the last edge that sampled a request
  task automatic begin_entry(output int e0);
    dpd_en = 1'b1;
    req_valid = 1'b1;
    tick(1);
    req_valid = 1'b0;
    e0 = cyc;
  endtask

  task automatic wait_status(logic [1:0] want, int limit, string req);
    int i;
    for (i = 0; i < limit; i++) begin
      if (status == want) break;
      tick(1);
    end
    chk(status == want, req, int'(status), int'(want));
  endtask

  task automatic check_log(int n_ref, bit pb, logic [7:0] open, int trp);
    int i = 0;
    int last_pre = -1;
    for (int r = 0; r < n_ref; r++) begin
      chk(lg_kind[i] == (pb ? 1 : 0), "R4", lg_kind[i], pb ? 1 : 0);
      if (pb) chk(lg_bank[i] == r, "R4", lg_bank[i], r);
      i++;
    end
    for (int b = 0; b < 8; b++) begin
      if (open[b]) begin
        chk(lg_kind[i] == 2 && lg_bank[i] == b, "R5", lg_bank[i], b);
        if (last_pre >= 0) chk(lg_cyc[i] == last_pre + 1, "R5", lg_cyc[i], last_pre + 1);
        last_pre = lg_cyc[i];
        i++;
      end
    end
    chk(lg_kind[i] == 3, "R7", lg_kind[i], 3);
    if (last_pre >= 0) chk(lg_cyc[i] - last_pre == trp + 2, "R6", lg_cyc[i] - last_pre, trp + 2);
    i++;
    chk(lg_n == i, "R5", lg_n, i);
  endtask

  initial begin
    int e0;
    int n0;
    int d;
    int tmo;
    void'($urandom(32'd20240611));

    // reset state
    do_reset();
    chk(status == 2'd0 && !cmd_valid && !dfi_lp_req, "R1", int'(status), 0);
    chk(cmd_cke == 1'b1 && cmd_cs_n == 2'b11, "R7", int'(cmd_cs_n), 3);

    // R1: each blocking control holds the block in idle
    tick(50);
    chk(status == 2'd0, "R1", int'(status), 0);
    for (int k = 0; k < 2; k++) begin
      do_reset();
      sr_en = (k == 0);
      sr_sw = (k == 1);
      begin_entry(e0);
      tick(60);
      chk(status == 2'd0, "R1", int'(status), 0);
    end

    // R2: exact idle period, then a basic run
    do_reset();
    open_banks = 8'b1010_0110;
    trp_cyc = 8'd3;
    begin_entry(e0);
    tick(32);
    chk(status == 2'd0, "R2", int'(status), 0);
    tick(1);
    chk(status == 2'd1, "R2", int'(status), 1);
    wait_status(2'd3, 200, "R6");
    tick(3);
    check_log(0, 1'b0, 8'b1010_0110, 3);

    // R9: requests and cleared controls after entry change nothing
    n0 = lg_n;
    dpd_en = 0; req_valid = 1; sr_en = 1;
    tick(12);
    chk(status == 2'd3 && !cmd_cke, "R9", int'(status), 3);
    chk(lg_n == n0, "R9", lg_n, n0);
    req_valid = 0;

    // R3: hardware gating
    do_reset();
    hwlp_en = 1;
    begin_entry(e0);
    tick(60);
    chk(status == 2'd0, "R3", int'(status), 0);
    hwlp_sr_done = 1;
    tick(2);
    chk(status == 2'd1, "R3", int'(status), 1);
    do_reset();
    act_gate_en = 1;
    activity = 4'b0100;
    begin_entry(e0);
    tick(60);
    chk(status == 2'd0, "R3", int'(status), 0);
    activity = '0;
    tick(2);
    chk(status == 2'd1, "R3", int'(status), 1);
    do_reset();
    activity = 4'hF;
    begin_entry(e0);
    tick(33);
    chk(status == 2'd1, "R3", int'(status), 1);

    // R4: refresh after self-refresh exit, both flavours
    do_reset();
    open_banks = 8'h01;
    sr_exit();
    begin_entry(e0);
    wait_status(2'd3, 300, "R4");
    tick(2);
    check_log(1, 1'b0, 8'h01, 2);
    do_reset();
    per_bank_ref = 1;
    open_banks = 8'h30;
    sr_exit();
    begin_entry(e0);
    wait_status(2'd3, 300, "R4");
    tick(2);
    check_log(8, 1'b1, 8'h30, 2);

    // R8: request during refresh aborts, pending refresh survives
    do_reset();
    per_bank_ref = 1;
    open_banks = 8'h81;
    sr_exit();
    begin_entry(e0);
    for (int i = 0; i < 200 && lg_n < 1; i++) tick(1);
    req_valid = 1;
    tick(1);
    chk(status == 2'd2, "R8", int'(status), 2);
    tick(1);
    chk(status == 2'd0, "R8", int'(status), 0);
    tick(10);
    chk(lg_n == 1, "R8", lg_n, 1);
    clear_log();
    req_valid = 0;
    wait_status(2'd3, 400, "R8");
    tick(2);
    check_log(8, 1'b1, 8'h81, 2);

    // R8: cleared enable during the tRP wait aborts
    do_reset();
    trp_cyc = 8'd30;
    begin_entry(e0);
    wait_status(2'd1, 100, "R8");
    tick(3);
    dpd_en = 0;
    tick(1);
    chk(status == 2'd2, "R8", int'(status), 2);
    tick(1);
    chk(status == 2'd0, "R8", int'(status), 0);
    tick(40);
    chk(lg_n == 0 && cmd_cke, "R8", lg_n, 0);

    // R12: a request while precharging does not abort
    do_reset();
    open_banks = 8'hFF;
    trp_cyc = 8'd1;
    begin_entry(e0);
    for (int i = 0; i < 200 && lg_n < 1; i++) tick(1);
    req_valid = 1;
    tick(1);
    req_valid = 0;
    wait_status(2'd3, 100, "R12");
    tick(2);
    check_log(0, 1'b0, 8'hFF, 1);

    // R10/R11: DFI request delay, wakeup value, timeout
    do_reset();
    dfi_lp_dpd_en = 1;
    t_ctrl_delay = 8'($urandom % 4);
    t_ckdpde = 8'($urandom % 4);
    dfi_timeout = 8'(3 + $urandom % 4);
    dfi_wakeup_cfg = 4'($urandom);
    open_banks = 8'h06;
    d = int'(t_ctrl_delay) + int'(t_ckdpde);
    tmo = int'(dfi_timeout);
    begin_entry(e0);
    wait_status(2'd3, 200, "R10");
    tick(30);
    chk(rise_cyc - lg_cyc[lg_n-1] == max1(d), "R10", rise_cyc - lg_cyc[lg_n-1], max1(d));
    chk(rise_wake == int'(dfi_wakeup_cfg), "R10", rise_wake, int'(dfi_wakeup_cfg));
    chk(fall_cyc - rise_cyc == max1(tmo), "R11", fall_cyc - rise_cyc, max1(tmo));

    // R11: acknowledge ends the request
    do_reset();
    dfi_lp_dpd_en = 1;
    dfi_timeout = 8'd50;
    begin_entry(e0);
    for (int i = 0; i < 300 && !dfi_lp_req; i++) tick(1);
    tick(1);
    dfi_lp_ack = 1;
    tick(2);
    dfi_lp_ack = 0;
    chk(fall_cyc - rise_cyc == 2, "R11", fall_cyc - rise_cyc, 2);

    // constrained random runs
    for (int it = 0; it < 10; it++) begin
      bit pend;
      bit pb;
      logic [7:0] ob;
      int trp;
      do_reset();
      pend = 1'($urandom % 2);
      pb = 1'($urandom % 2);
      ob = 8'($urandom);
      trp = int'($urandom % 6);
      idle_x32 = 8'($urandom % 3);
      per_bank_ref = pb;
      open_banks = ob;
      trp_cyc = 8'(trp);
      if (pend) sr_exit();
      begin_entry(e0);
      wait_status(2'd3, 600, "R5");
      tick(4);
      check_log(pend ? (pb ? 8 : 1) : 0, pb, ob, trp);
      chk(rise_cyc == -1, "R10", rise_cyc, -1);
    end

    finish_run();
  end
endmodule